// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drives the transmit side of a frame controller from a ring of descriptors kept in a small descriptor RAM. Each descriptor takes two consecutive words: a control/status word at an even index, and a byte pointer to the frame buffer at the next index. While transmission is enabled, the engine polls the current descriptor. When the descriptor is marked ready, the engine clears its stale status fields and works out the frame policy: the effective minimum and maximum length, and whether a CRC must be appended. It then reads the buffer from memory one 32-bit word at a time and streams the bytes out, most significant byte first.

When the frame ends, the engine writes the status word back with the ready bit cleared. It then signals a done or error event, raises an interrupt request when the descriptor asks for one and the matching mask is set, and steps to the next descriptor. A host reaches the same RAM through a simple word-wide bus port to build descriptors and read back status. A host access always wins the RAM in its cycle, and the engine waits.

The CRC generator, collision handling and the line interface sit outside this block. The engine only publishes the policy it derived for them.

Top module: `txbd_engine`

## Requirements
- R1: After reset, and for as long as `tx_enable` is low while the engine is idle, no memory read is requested, no byte is presented and no event fires, even when a ready descriptor is waiting.
- R2: A descriptor is accepted only when bit 15 (ready) of its control word is set. A descriptor that is not ready is re-polled and causes no memory read.
- R3: The status word is written back at the descriptor's own index. In it, bit 15 (ready), bit 8 (underrun), bits 7:4 (retry count) and bits 3:0 (retransmit, collision, defer, no-carrier) are zero, and every other bit is preserved, including the length in bits 31:16.
- R4: `frm_min_len` equals `cfg_min_len` when descriptor bit 12 (pad) or `pad_mode` is set. Otherwise it equals the descriptor length.
- R5: `frm_max_len` equals the descriptor length when `huge_mode` is set. Otherwise it equals `cfg_max_len`.
- R6: `frm_crc` is set when `crc_mode` is set, or when descriptor bit 11 (CRC) and bit 10 (last) are both set.
- R7: A frame of length L issues ceil(L/4) word reads at the buffer pointer plus 0, 4, 8 and so on, holding `mem_rd` and `mem_addr` until `mem_rvalid`. Exactly L bytes are emitted, each word as bits 31:24 first, and `tx_last` marks only the final byte.
- R8: While `tx_valid` is high and `tx_ready` is low, the presented byte stays unchanged.
- R9: A completed frame pulses `evt_done`. A read answered with `mem_err` pulses `evt_err` instead, stops the stream and still writes the status back. The two never fire together.
- R10: `irq` pulses with an event only when descriptor bit 14 is set and `mask_done` (for done) or `mask_err` (for error) is set.
- R11: After each frame the descriptor index steps by 2. It returns to 0 when descriptor bit 13 (wrap) is set or when the index is the last pair of the RAM.
- R12: A bus read or write is served in the cycle it is presented. An engine access to the RAM waits until the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmit enable |
| pad_mode | input | 1 | Global pad-to-minimum mode |
| huge_mode | input | 1 | Global oversize-frame mode |
| crc_mode | input | 1 | Global CRC append mode |
| cfg_min_len | input | 16 | Configured minimum frame length |
| cfg_max_len | input | 16 | Configured maximum frame length |
| mask_done | input | 1 | Interrupt mask for done events |
| mask_err | input | 1 | Interrupt mask for error events |
| bus_wr | input | 1 | Host write to descriptor RAM |
| bus_rd | input | 1 | Host read from descriptor RAM |
| bus_addr | input | IDX_W | Host word index |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid the cycle after `bus_rd` |
| mem_rd | output | 1 | Buffer word read request |
| mem_addr | output | ADDR_W | Buffer byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response word |
| mem_err | input | 1 | Read response error, qualified by `mem_rvalid` |
| tx_valid | output | 1 | Byte valid |
| tx_ready | input | 1 | Byte accepted |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of frame |
| frm_min_len | output | 16 | Effective minimum length of current frame |
| frm_max_len | output | 16 | Effective maximum length of current frame |
| frm_crc | output | 1 | CRC to be appended to current frame |
| evt_done | output | 1 | Frame completed pulse |
| evt_err | output | 1 | Frame failed pulse |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench builds the engine with an 8-word descriptor RAM, so the ring holds four descriptors. This brings the end-of-RAM return to index 0 within reach every fourth frame, alongside the explicit wrap bit. Frame lengths 0 to 9 under a stalling byte sink cover every residue of the final partial word. All 64 combinations of the three global modes and the three descriptor policy bits are swept. Memory errors, every mask and interrupt-bit pairing, a descriptor that is not ready, a disabled engine, and a stretch of back-to-back host reads during a frame complete the sweep.

// File: rtl/txbd_pkg.sv
package txbd_pkg;

  localparam int LEN_W = 16;

  // Control word field positions (decoded by software and by this engine)
  localparam int BD_LEN_LSB = 16;
  localparam int BD_READY   = 15;
  localparam int BD_IRQ     = 14;
  localparam int BD_WRAP    = 13;
  localparam int BD_PAD     = 12;
  localparam int BD_CRC     = 11;
  localparam int BD_LAST    = 10;

  // Underrun, retry count and the four line status flags
  localparam logic [31:0] BD_STAT_CLR   = 32'h0000_01FF;
  localparam logic [31:0] BD_READY_MASK = 32'h0000_8000;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_BD = 2'd1,
    ST_FETCH   = 2'd2,
    ST_XMIT    = 2'd3
  } txbd_state_e;

  typedef struct packed {
    logic [LEN_W-1:0] min_len;
    logic [LEN_W-1:0] max_len;
    logic             crc;
  } txbd_policy_t;

endpackage

// File: rtl/txbd_desc_ram.sv
module txbd_desc_ram #(
  parameter int WORDS = 128,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [IDX_W-1:0] bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             eng_rd,
  input  logic             eng_wr,
  input  logic [IDX_W-1:0] eng_addr,
  input  logic [31:0]      eng_wdata,
  output logic [31:0]      eng_rdata,
  output logic             eng_gnt
);

  logic [31:0]      mem_q [WORDS];
  logic [31:0]      bus_rdata_q;
  logic [31:0]      eng_rdata_q;
  logic             we;
  logic [IDX_W-1:0] waddr;
  logic [31:0]      wdata;
  logic             eng_rd_en;

  // Host side owns the array in any cycle it touches it
  always_comb begin
    eng_gnt   = !(bus_wr || bus_rd);
    we        = bus_wr || (eng_wr && eng_gnt);
    waddr     = bus_wr ? bus_addr  : eng_addr;
    wdata     = bus_wr ? bus_wdata : eng_wdata;
    eng_rd_en = eng_rd && eng_gnt;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata_q <= '0;
      eng_rdata_q <= '0;
    end else begin
      if (bus_rd) begin
        bus_rdata_q <= mem_q[bus_addr];
      end
      if (eng_rd_en) begin
        eng_rdata_q <= mem_q[eng_addr];
      end
    end
  end

  assign bus_rdata = bus_rdata_q;
  assign eng_rdata = eng_rdata_q;

endmodule

// File: rtl/txbd_policy.sv
module txbd_policy
  import txbd_pkg::*;
(
  input  logic [LEN_W-1:0] len_i,
  input  logic             pad_bd,
  input  logic             crc_bd,
  input  logic             last_bd,
  input  logic             pad_mode,
  input  logic             huge_mode,
  input  logic             crc_mode,
  input  logic [LEN_W-1:0] cfg_min,
  input  logic [LEN_W-1:0] cfg_max,
  output txbd_policy_t     pol_o
);

  always_comb begin
    pol_o.min_len = (pad_bd || pad_mode) ? cfg_min : len_i;
    pol_o.max_len = huge_mode ? len_i : cfg_max;
    pol_o.crc     = crc_mode || (crc_bd && last_bd);
  end

endmodule

// File: rtl/txbd_byteser.sv
module txbd_byteser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        load,
  input  logic [31:0] word_i,
  input  logic        take,
  output logic [7:0]  byte_o,
  output logic        has_byte
);

  logic [31:0] sh_q, sh_d;
  logic [2:0]  cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = 3'd0;
    end else if (load) begin
      sh_d  = word_i;
      cnt_d = 3'd4;
    end else if (take && (cnt_q != 3'd0)) begin
      sh_d  = {sh_q[23:0], 8'h00};
      cnt_d = cnt_q - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign byte_o   = sh_q[31:24];
  assign has_byte = (cnt_q != 3'd0);

endmodule

// File: rtl/txbd_engine.sv
module txbd_engine
  import txbd_pkg::*;
#(
  parameter int DESC_WORDS = 128,
  parameter int ADDR_W     = 32,
  localparam int IDX_W     = $clog2(DESC_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              pad_mode,
  input  logic              huge_mode,
  input  logic              crc_mode,
  input  logic [15:0]       cfg_min_len,
  input  logic [15:0]       cfg_max_len,
  input  logic              mask_done,
  input  logic              mask_err,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic [15:0]       frm_min_len,
  output logic [15:0]       frm_max_len,
  output logic              frm_crc,
  output logic              evt_done,
  output logic              evt_err,
  output logic              irq
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 2);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  txbd_state_e      st_q, st_d;
  logic [1:0]       ph_q, ph_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [31:0]      ctrl_q, ctrl_d;
  logic [31:0]      ptr_q, ptr_d;
  logic [LEN_W-1:0] sent_q, sent_d;
  logic [LEN_W:0]   fetched_q, fetched_d;
  logic             err_q, err_d;
  txbd_policy_t     pol_q, pol_d, pol_now;

  logic             eng_rd, eng_wr, eng_gnt;
  logic [IDX_W-1:0] eng_addr;
  logic [31:0]      eng_wdata, eng_rdata;
  logic             ser_clr, ser_load, ser_take, ser_has;
  logic [7:0]       ser_byte;
  logic [LEN_W-1:0] len;

  assign len = ctrl_q[BD_LEN_LSB +: LEN_W];

  txbd_desc_ram #(.WORDS(DESC_WORDS), .IDX_W(IDX_W)) u_ram (
    .clk       (clk),
    .rst_n     (rst_ni),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .eng_rd    (eng_rd),
    .eng_wr    (eng_wr),
    .eng_addr  (eng_addr),
    .eng_wdata (eng_wdata),
    .eng_rdata (eng_rdata),
    .eng_gnt   (eng_gnt)
  );

  txbd_policy u_pol (
    .len_i     (len),
    .pad_bd    (ctrl_q[BD_PAD]),
    .crc_bd    (ctrl_q[BD_CRC]),
    .last_bd   (ctrl_q[BD_LAST]),
    .pad_mode  (pad_mode),
    .huge_mode (huge_mode),
    .crc_mode  (crc_mode),
    .cfg_min   (cfg_min_len),
    .cfg_max   (cfg_max_len),
    .pol_o     (pol_now)
  );

  txbd_byteser u_ser (
    .clk      (clk),
    .rst_n    (rst_ni),
    .clr      (ser_clr),
    .load     (ser_load),
    .word_i   (mem_rdata),
    .take     (ser_take),
    .byte_o   (ser_byte),
    .has_byte (ser_has)
  );

  // Next-state logic
  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    idx_d     = idx_q;
    ctrl_d    = ctrl_q;
    ptr_d     = ptr_q;
    sent_d    = sent_q;
    fetched_d = fetched_q;
    err_d     = err_q;
    pol_d     = pol_q;
    eng_rd    = 1'b0;
    eng_wr    = 1'b0;
    eng_addr  = idx_q;
    eng_wdata = ctrl_q & ~BD_READY_MASK;
    ser_clr   = 1'b0;
    ser_load  = 1'b0;
    ser_take  = 1'b0;
    mem_rd    = 1'b0;
    tx_valid  = 1'b0;
    evt_done  = 1'b0;
    evt_err   = 1'b0;
    irq       = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (tx_enable) begin
          st_d = ST_WAIT_BD;
          ph_d = 2'd0;
        end
      end

      ST_WAIT_BD: begin
        unique case (ph_q)
          2'd0: begin
            if (!tx_enable) begin
              st_d = ST_IDLE;
            end else begin
              eng_rd = 1'b1;
              if (eng_gnt) ph_d = 2'd1;
            end
          end
          2'd1: begin
            if (eng_rdata[BD_READY]) begin
              ctrl_d    = eng_rdata & ~BD_STAT_CLR;
              sent_d    = '0;
              fetched_d = '0;
              err_d     = 1'b0;
              ser_clr   = 1'b1;
              ph_d      = 2'd2;
            end else begin
              ph_d = 2'd0;
            end
          end
          2'd2: begin
            eng_rd   = 1'b1;
            eng_addr = idx_q + IDX_W'(1);
            if (eng_gnt) ph_d = 2'd3;
          end
          default: begin
            ptr_d = eng_rdata;
            pol_d = pol_now;
            st_d  = ST_FETCH;
            ph_d  = 2'd0;
          end
        endcase
      end

      ST_FETCH: begin
        if (sent_q == len) begin
          st_d = ST_XMIT;
        end else if (ser_has) begin
          tx_valid = 1'b1;
          if (tx_ready) begin
            ser_take = 1'b1;
            sent_d   = sent_q + LEN_W'(1);
          end
        end else begin
          mem_rd = 1'b1;
          if (mem_rvalid) begin
            if (mem_err) begin
              err_d = 1'b1;
              st_d  = ST_XMIT;
            end else begin
              ser_load  = 1'b1;
              fetched_d = fetched_q + (LEN_W+1)'(4);
            end
          end
        end
      end

      default: begin
        eng_wr = 1'b1;
        if (eng_gnt) begin
          evt_done = !err_q;
          evt_err  = err_q;
          irq      = ctrl_q[BD_IRQ] && (err_q ? mask_err : mask_done);
          if (ctrl_q[BD_WRAP] || (idx_q >= LAST_IDX)) idx_d = '0;
          else                                         idx_d = idx_q + IDX_W'(2);
          st_d = ST_WAIT_BD;
          ph_d = 2'd0;
        end
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ph_q      <= '0;
      idx_q     <= '0;
      ctrl_q    <= '0;
      ptr_q     <= '0;
      sent_q    <= '0;
      fetched_q <= '0;
      err_q     <= 1'b0;
      pol_q     <= '0;
    end else begin
      st_q      <= st_d;
      ph_q      <= ph_d;
      idx_q     <= idx_d;
      ctrl_q    <= ctrl_d;
      ptr_q     <= ptr_d;
      sent_q    <= sent_d;
      fetched_q <= fetched_d;
      err_q     <= err_d;
      pol_q     <= pol_d;
    end
  end

  assign mem_addr    = ptr_q[ADDR_W-1:0] + ADDR_W'(fetched_q);
  assign tx_data     = ser_byte;
  assign tx_last     = tx_valid && (sent_q == (len - LEN_W'(1)));
  assign frm_min_len = pol_q.min_len;
  assign frm_max_len = pol_q.max_len;
  assign frm_crc     = pol_q.crc;

endmodule

// File: rtl/txbd_engine_chk.sv
module txbd_engine_chk
  import txbd_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_enable,
  input txbd_state_e       st,
  input logic [IDX_W-1:0]  idx,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_last,
  input logic              evt_done,
  input logic              evt_err,
  input logic              irq,
  input logic              mask_done,
  input logic              mask_err
);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !tx_enable) |=> (st == ST_IDLE));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));

  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R8
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R9
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_done && evt_err));

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((evt_done && mask_done) || (evt_err && mask_err)));

  // R11
  even_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done || evt_err) |=> !idx[0]);

  // R12
  bus_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && st == ST_XMIT) |=> (st == ST_XMIT));

endmodule

bind txbd_engine txbd_engine_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_enable  (tx_enable),
  .st         (st_q),
  .idx        (idx_q),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .mem_rd     (mem_rd),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .tx_last    (tx_last),
  .evt_done   (evt_done),
  .evt_err    (evt_err),
  .irq        (irq),
  .mask_done  (mask_done),
  .mask_err   (mask_err)
);

// File: tb/txbd_engine_bench.sv
`timescale 1ns/1ps
module txbd_engine_bench;

  localparam int W  = 8;
  localparam int IW = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_enable, pad_mode, huge_mode, crc_mode;
  logic [15:0] cfg_min_len, cfg_max_len;
  logic        mask_done, mask_err;
  logic        bus_wr, bus_rd;
  logic [IW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        mem_rd, mem_rvalid, mem_err;
  logic [31:0] mem_addr, mem_rdata;
  logic        tx_valid, tx_ready, tx_last;
  logic [7:0]  tx_data;
  logic [15:0] frm_min_len, frm_max_len;
  logic        frm_crc, evt_done, evt_err, irq;

  always #2.5 clk = ~clk;

  txbd_engine #(.DESC_WORDS(W), .ADDR_W(32)) u_txbd_engine (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .pad_mode(pad_mode),
    .huge_mode(huge_mode), .crc_mode(crc_mode), .cfg_min_len(cfg_min_len),
    .cfg_max_len(cfg_max_len), .mask_done(mask_done), .mask_err(mask_err),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .frm_min_len(frm_min_len), .frm_max_len(frm_max_len), .frm_crc(frm_crc),
    .evt_done(evt_done), .evt_err(evt_err), .irq(irq)
  );

  int checks = 0, fails = 0, cyc = 0;
  int n_done = 0, n_err = 0, n_irq = 0;
  int cap_n = 0, rd_cnt = 0, last_cnt = 0, last_pos = -1;
  logic [7:0]  cap [256];
  logic [31:0] first_addr = '0;
  logic [15:0] cap_min = '0, cap_max = '0;
  logic        cap_crc = 1'b0;
  logic        bp_en = 1'b0, tog = 1'b0, err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int          idx_exp = 0;
  logic [31:0] cur_ctrl, cur_ptr;
  int          cur_len, ev0, irq0;

  function automatic logic [7:0] bval(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] wordat(input logic [31:0] a);
    return {bval(a), bval(a + 32'd1), bval(a + 32'd2), bval(a + 32'd3)};
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory responder, byte sink and event counters, all away from the active edge
  always @(negedge clk) begin
    if (mem_rd && !mem_rvalid) begin
      mem_rvalid = 1'b1;
      mem_rdata  = wordat(mem_addr);
      mem_err    = err_en && (mem_addr == err_addr);
      if (rd_cnt == 0) first_addr = mem_addr;
      rd_cnt++;
    end else begin
      mem_rvalid = 1'b0;
      mem_err    = 1'b0;
    end
    tog      = ~tog;
    tx_ready = bp_en ? tog : 1'b1;
    if (tx_valid && tx_ready) begin
      if (cap_n == 0) begin
        cap_min = frm_min_len; cap_max = frm_max_len; cap_crc = frm_crc;
      end
      if (cap_n < 256) cap[cap_n] = tx_data;
      if (tx_last) begin last_cnt++; last_pos = cap_n; end
      cap_n++;
    end
    if (evt_done) n_done++;
    if (evt_err)  n_err++;
    if (irq)      n_irq++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = IW'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = IW'(a);
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic clear_capture();
    cap_n = 0; rd_cnt = 0; last_cnt = 0; last_pos = -1;
    ev0 = n_done + n_err; irq0 = n_irq;
  endtask

  task automatic post_desc(input int len, input logic [31:0] ptr, input logic [15:0] low);
    clear_capture();
    cur_len  = len;
    cur_ptr  = ptr;
    cur_ctrl = {16'(len), low | 16'h8000};
    bus_write(idx_exp + 1, ptr);
    bus_write(idx_exp, cur_ctrl);
  endtask

  task automatic wait_end();
    int t = 0;
    while ((n_done + n_err) == ev0 && t < 4000) begin
      @(posedge clk); t++;
    end
    chk("R11", "frame completion at expected index", (n_done + n_err) - ev0, 1);
    @(posedge clk); #1;
  endtask

  task automatic check_frame(input bit is_err, input int err_word);
    int nb, nrd, bad;
    logic [31:0] st;
    nb  = is_err ? err_word * 4 : cur_len;
    nrd = is_err ? err_word + 1 : (cur_len + 3) / 4;
    chk("R7", "byte count", cap_n, nb);
    bad = 0;
    for (int k = 0; k < nb && k < 256; k++)
      if (cap[k] !== bval(cur_ptr + 32'(k))) bad++;
    chk("R7", "byte order mismatches", bad, 0);
    chk("R7", "word reads", rd_cnt, nrd);
    if (nrd > 0) chk("R7", "first read address", first_addr, cur_ptr);
    chk("R7", "tx_last count", last_cnt, (!is_err && cur_len > 0) ? 1 : 0);
    if (!is_err && cur_len > 0) chk("R7", "tx_last position", last_pos, cur_len - 1);
    bus_read(idx_exp, st);
    chk("R3", "status write-back", st, cur_ctrl & ~32'h0000_81FF);
    if (cur_ctrl[13] || idx_exp >= W - 2) idx_exp = 0;
    else                                  idx_exp = idx_exp + 2;
  endtask

  task automatic hammer(input int a, input logic [31:0] v, input int n);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = IW'(a);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      chk("R12", "host read under engine load", bus_rdata, v);
    end
    bus_rd = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    int e0, d0;
    rst_n = 1'b0; tx_enable = 1'b0; pad_mode = 1'b0; huge_mode = 1'b0; crc_mode = 1'b0;
    cfg_min_len = 16'd60; cfg_max_len = 16'd1536; mask_done = 1'b1; mask_err = 1'b1;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    mem_rvalid = 1'b0; mem_err = 1'b0; mem_rdata = '0; tx_ready = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "tx_valid after reset", tx_valid, 0);
    chk("R1", "mem_rd after reset", mem_rd, 0);
    chk("R1", "events after reset", n_done + n_err + n_irq, 0);
    for (int a = 0; a < W; a++) bus_write(a, 32'h0);

    // R1: ready descriptor while disabled stays untouched
    post_desc(10, 32'h100, 16'h03FF);
    repeat (40) @(posedge clk);
    #1;
    chk("R1", "reads while disabled", rd_cnt, 0);
    chk("R1", "bytes while disabled", cap_n, 0);
    tx_enable = 1'b1;
    wait_end();
    check_frame(1'b0, 0);
    chk("R10", "no irq without descriptor bit", n_irq - irq0, 0);

    // R7 R8 R11: length sweep with a stalling sink, walking the whole ring
    bp_en = 1'b1;
    for (int len = 0; len < 10; len++) begin
      post_desc(len, 32'h200 + 32'(len * 32), 16'h03FF);
      wait_end();
      check_frame(1'b0, 0);
    end
    bp_en = 1'b0;

    // R11: end-of-RAM return, then explicit wrap at index 0
    chk("R11", "bench index before wrap test", idx_exp, 6);
    post_desc(7, 32'h400, 16'h0000);
    wait_end(); check_frame(1'b0, 0);
    post_desc(6, 32'h480, 16'h2000);
    wait_end(); check_frame(1'b0, 0);
    post_desc(5, 32'h500, 16'h0000);
    wait_end(); check_frame(1'b0, 0);

    // R2: not-ready descriptor is polled without fetching
    clear_capture();
    cur_len = 9; cur_ptr = 32'h580; cur_ctrl = {16'd9, 16'h8000};
    bus_write(idx_exp + 1, cur_ptr);
    bus_write(idx_exp, {16'd9, 16'h0000});
    repeat (40) @(posedge clk);
    #1;
    chk("R2", "reads on not-ready descriptor", rd_cnt, 0);
    chk("R2", "events on not-ready descriptor", (n_done + n_err) - ev0, 0);
    bus_write(idx_exp, cur_ctrl);
    wait_end(); check_frame(1'b0, 0);

    // R10: interrupt bit against done mask
    mask_err = 1'b1;
    for (int c = 0; c < 4; c++) begin
      mask_done = c[1];
      post_desc(4, 32'h600 + 32'(c * 16), c[0] ? 16'h4000 : 16'h0000);
      wait_end();
      chk("R10", "done irq pulses", n_irq - irq0, (c[0] && c[1]) ? 1 : 0);
      check_frame(1'b0, 0);
    end
    mask_done = 1'b1;

    // R9 R10: memory error aborts the frame
    for (int c = 0; c < 2; c++) begin
      mask_err = c[0];
      err_en = 1'b1; err_addr = 32'h704;
      d0 = n_done; e0 = n_err;
      post_desc(12, 32'h700, 16'h4000);
      wait_end();
      chk("R9", "error event", n_err - e0, 1);
      chk("R9", "no done on error", n_done - d0, 0);
      chk("R10", "error irq pulses", n_irq - irq0, c[0] ? 1 : 0);
      err_en = 1'b0;
      check_frame(1'b1, 1);
    end
    mask_err = 1'b1;

    // R4 R5 R6: all policy flag and mode combinations
    for (int c = 0; c < 64; c++) begin
      logic [15:0] low;
      pad_mode = c[1]; huge_mode = c[2]; crc_mode = c[3];
      low = {3'b000, c[0], c[4], c[5], 10'h000};
      post_desc(5, 32'h800 + 32'(c * 8), low);
      wait_end();
      chk("R4", "effective minimum", cap_min, (c[0] || c[1]) ? 60 : 5);
      chk("R5", "effective maximum", cap_max, c[2] ? 5 : 1536);
      chk("R6", "crc decision", cap_crc, (c[3] || (c[4] && c[5])) ? 1 : 0);
      check_frame(1'b0, 0);
    end
    pad_mode = 1'b0; huge_mode = 1'b0; crc_mode = 1'b0;

    // R12: back-to-back host reads during a frame
    bus_write((idx_exp + 3) % W, 32'hC0DE_5A5A);
    bp_en = 1'b1;
    post_desc(8, 32'hA00, 16'h0000);
    fork
      hammer((idx_exp + 3) % W, 32'hC0DE_5A5A, 30);
      wait_end();
    join
    check_frame(1'b0, 0);
    bp_en = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule